// File: doc/BRIEF.md
# Asynchronous serial receiver with per-character status queue

This block recovers characters from an asynchronous serial line that is oversampled by a baud tick. The tick comes from outside at 16 times the bit rate. A character carries 5 to 9 data bits, least significant first, and may carry an even or odd parity bit. A first stop bit follows. The line first passes through a two-stage synchronizer. Each bit is then decided by a two-of-three vote over the middle samples. This filters short glitches and rejects start bits that do not last.

Each finished character is first held in the receive shift register. From there it moves into a two-entry circular queue. The frame-error flag, the parity-error flag, the overrun flag and the ninth data bit are stored in the queue together with the data. The status outputs therefore always describe the character at the head of the queue. A host reads the status outputs first and then pulses the pop input, which consumes that entry. When both queue entries are full, the shift register keeps a third character. Data is lost only when a further start bit arrives while that third character is still waiting.

Top module: `uart_rx_fifo`

## Requirements
- R1: `cfg_bits` selects the data width as 5 + `cfg_bits` (values 0 to 4; larger values mean 9). Data bits arrive least significant first and appear right-justified on `rd_data` (bits 7:0) and `rd_bit8` (bit 8). Bits above the selected width read as 0.
- R2: `cfg_par` selects the parity mode: 00 or 01 means no parity bit, 10 means even, 11 means odd. `rd_perr` is 1 when the received parity bit does not match the data under the selected mode.
- R3: `rd_ferr` is 1 when the first stop bit is sampled low. The receiver looks at one stop bit only, so frames that follow one another directly after a single stop bit are all received without error.
- R4: A start bit is accepted only when at least two of samples 8, 9 and 10 are low. A shorter low pulse returns the receiver to idle and stores nothing.
- R5: Every data, parity and stop bit takes the majority value of samples 8, 9 and 10. A glitch that lasts one sample does not change a received bit.
- R6: The queue holds two entries and returns them in arrival order. `rx_ready` is 1 exactly when the queue is not empty. A pulse on `rd_pop` removes one entry, and a pulse on `rd_pop` while the queue is empty has no effect.
- R7: While both queue entries are full, a third finished character stays in the shift register and enters the queue after the next pop. No flag is set for it.
- R8: When a start bit is accepted while the queue is full and the shift register still holds a character, that character is lost. The next character stored then has `rd_ovr` = 1.
- R9: After reset, `rx_ready` is 0 and all head status outputs and data are 0.
- R10: The status flags belong to each entry. After a pop, the flags shown are those of the new head character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Sample enable at 16 times the bit rate |
| rxd | input | 1 | Serial input line, idles high |
| cfg_bits | input | 3 | Data width code, width = 5 + code |
| cfg_par | input | 2 | Parity mode: 0x none, 10 even, 11 odd |
| rd_pop | input | 1 | Consume the head entry |
| rx_ready | output | 1 | Queue is not empty |
| rd_data | output | 8 | Head data bits 7:0 |
| rd_bit8 | output | 1 | Head data bit 8 |
| rd_ferr | output | 1 | Head frame error |
| rd_perr | output | 1 | Head parity error |
| rd_ovr | output | 1 | A character was lost before the head entry |

## Verification
Several properties are checked on every cycle: the queue occupancy bound, a full queue that cannot change without a pop, the last pop that empties the queue, a held third character that stays put until something frees room or overwrites it, and the overrun mark that is raised when the held character is lost. The bench scenarios are the only way to show the actual recovered values: data width, bit order, parity results, frame errors, glitch immunity, false-start rejection, and the order in which the three buffered characters and the overrun flag come out.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic [2:0] cfg_bits,
  input  logic [1:0] cfg_par,
  input  logic       rd_pop,
  output logic       rx_ready,
  output logic [7:0] rd_data,
  output logic       rd_bit8,
  output logic       rd_ferr,
  output logic       rd_perr,
  output logic       rd_ovr
);
  localparam int CW = $clog2(OSR + 1);
  localparam logic [CW-1:0] S_END = CW'(OSR);
  localparam logic [CW-1:0] S_A   = CW'(OSR / 2);
  localparam logic [CW-1:0] S_B   = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] S_C   = CW'(OSR / 2 + 2);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} st_t;

  st_t         st;
  logic [1:0]  sync;
  logic [CW-1:0] smp;
  logic [1:0]  vote;
  logic [3:0]  nbit;
  logic [8:0]  sh;
  logic        pbit;
  logic        hold_v, ovr_pend;
  logic [11:0] hold;
  logic [11:0] mem [2];
  logic        wp, rp;
  logic [1:0]  cnt;

  wire         rx_s   = sync[1];
  wire [CW-1:0] smp_n = smp + 1'b1;
  wire         decide = baud_tick && (st != IDLE) && (smp_n == S_C);
  wire         maj    = (vote[1] & vote[0]) | (vote[1] & rx_s) | (vote[0] & rx_s);
  wire [3:0]   nb     = (cfg_bits > 3'd4) ? 4'd9 : {1'b0, cfg_bits} + 4'd5;
  wire [8:0]   dj     = sh >> (4'd9 - nb);
  wire         perr   = cfg_par[1] && ((^dj ^ pbit) != cfg_par[0]);
  wire         start_ok = decide && (st == START) && !maj;
  wire         done   = decide && (st == STOP);
  wire         pop    = rd_pop && (cnt != 2'd0);
  wire         xfer   = hold_v && ((cnt != 2'd2) || pop);
  wire         lost   = start_ok && hold_v && !xfer;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; smp <= '0; vote <= '0; nbit <= '0; sh <= '0; pbit <= 1'b0;
    end else if (baud_tick) begin
      if (st == IDLE) begin
        if (!rx_s) begin
          st  <= START;
          smp <= CW'(1);
        end
      end else begin
        smp <= (smp_n == S_END) ? '0 : smp_n;
        if (smp_n == S_A || smp_n == S_B) vote <= {vote[0], rx_s};
        if (decide) begin
          case (st)
            START: begin
              nbit <= '0;
              if (maj) st <= IDLE;
            end
            DATA: begin
              sh   <= {maj, sh[8:1]};
              nbit <= nbit + 4'd1;
            end
            PAR:  pbit <= maj;
            STOP: st <= IDLE;
            default: st <= IDLE;
          endcase
        end
        if (smp_n == S_END) begin
          case (st)
            START: st <= DATA;
            DATA:  if (nbit == nb) st <= cfg_par[1] ? PAR : STOP;
            PAR:   st <= STOP;
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0; ovr_pend <= 1'b0; hold <= '0;
    end else begin
      if (done) begin
        hold     <= {ovr_pend, perr, !maj, dj};
        ovr_pend <= 1'b0;
        hold_v   <= 1'b1;
      end else if (lost) begin
        ovr_pend <= 1'b1;
        hold_v   <= 1'b0;
      end else if (xfer) begin
        hold_v   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem[0] <= '0; mem[1] <= '0; wp <= 1'b0; rp <= 1'b0; cnt <= '0;
    end else begin
      if (xfer) begin
        mem[wp] <= hold;
        wp      <= ~wp;
      end
      if (pop) rp <= ~rp;
      cnt <= cnt + {1'b0, xfer} - {1'b0, pop};
    end
  end

  assign rx_ready = (cnt != 2'd0);
  assign rd_data  = mem[rp][7:0];
  assign rd_bit8  = mem[rp][8];
  assign rd_ferr  = mem[rp][9];
  assign rd_perr  = mem[rp][10];
  assign rd_ovr   = mem[rp][11];
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_pop,
  input logic       rx_ready,
  input logic [1:0] cnt,
  input logic       hold_v,
  input logic       ovr_pend,
  input logic       lost,
  input logic       start_ok,
  input logic       xfer
);
  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= 2'd2);
  // R6
  full_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd2 && !rd_pop) |=> cnt == 2'd2);
  // R6
  last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && cnt == 2'd1 && !xfer) |=> !rx_ready);
  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && cnt == 2'd2 && !rd_pop && !start_ok) |=> hold_v);
  // R8
  ovr_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> (ovr_pend && !hold_v));
  // R9
  reset_empty_chk: assert property (@(posedge clk) !rst_n |=> cnt == 2'd0);
endmodule

bind uart_rx_fifo uart_rx_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_pop(rd_pop), .rx_ready(rx_ready), .cnt(cnt),
  .hold_v(hold_v), .ovr_pend(ovr_pend), .lost(lost), .start_ok(start_ok), .xfer(xfer)
);

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;
  localparam int TDIV = 2;
  localparam int BITCLK = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick;
  logic       rxd = 1'b1;
  logic [2:0] cfg_bits = 3'd3;
  logic [1:0] cfg_par = 2'b00;
  logic       rd_pop = 1'b0;
  logic       rx_ready, rd_bit8, rd_ferr, rd_perr, rd_ovr;
  logic [7:0] rd_data;
  int         total = 0, bad = 0;
  int         tdiv = 0;
  bit         finished = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) tdiv <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
  assign baud_tick = (tdiv == 0);

  uart_rx_fifo dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .cfg_bits(cfg_bits), .cfg_par(cfg_par), .rd_pop(rd_pop),
    .rx_ready(rx_ready), .rd_data(rd_data), .rd_bit8(rd_bit8),
    .rd_ferr(rd_ferr), .rd_perr(rd_perr), .rd_ovr(rd_ovr)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input bit glitch);
    for (int c = 0; c < BITCLK; c++) begin
      @(negedge clk);
      rxd = (glitch && c == BITCLK / 2 + 2) ? ~v : v;
    end
  endtask

  task automatic idle(input int bits);
    rxd = 1'b1;
    repeat (bits * BITCLK) @(negedge clk);
  endtask

  // par: 0 none, 2 even, 3 odd
  task automatic send(input logic [8:0] d, input int nb, input int par,
                      input bit bad_par, input bit stop_low, input bit glitch);
    logic p;
    drive_bit(1'b0, 1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i], glitch);
    if (par >= 2) begin
      p = 1'b0;
      for (int i = 0; i < nb; i++) p = p ^ d[i];
      p = p ^ (par == 3) ^ bad_par;
      drive_bit(p, glitch);
    end
    drive_bit(~stop_low, 1'b0);
    rxd = 1'b1;
  endtask

  task automatic pop_one;
    @(negedge clk) rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_head(input string req, input logic [8:0] d, input bit fe,
                            input bit pe, input bit ov);
    check(req, "ready", rx_ready, 1);
    check(req, "data", rd_data, d[7:0]);
    check(req, "bit8", rd_bit8, d[8]);
    check(req, "ferr", rd_ferr, fe);
    check(req, "perr", rd_perr, pe);
    check(req, "ovr", rd_ovr, ov);
  endtask

  task automatic t_reset;
    check("R9", "ready", rx_ready, 0);
    check("R9", "data", rd_data, 0);
    check("R9", "flags", {rd_bit8, rd_ferr, rd_perr, rd_ovr}, 0);
  endtask

  task automatic t_widths;
    logic [8:0] pat;
    cfg_par = 2'b00;
    for (int w = 5; w <= 9; w++) begin
      cfg_bits = 3'(w - 5);
      pat = 9'h1A5 & 9'((1 << w) - 1);
      send(9'h1A5, w, 0, 0, 0, 0);
      idle(2);
      check_head("R1", pat, 0, 0, 0);
      pop_one();
      check("R6", "empty after pop", rx_ready, 0);
    end
    cfg_bits = 3'd3;
  endtask

  task automatic t_parity;
    cfg_bits = 3'd3;
    cfg_par = 2'b10;
    send(9'h0B7, 8, 2, 0, 0, 0); idle(2);
    check_head("R2", 9'h0B7, 0, 0, 0); pop_one();
    cfg_par = 2'b11;
    send(9'h0B7, 8, 3, 0, 0, 0); idle(2);
    check_head("R2", 9'h0B7, 0, 0, 0); pop_one();
    cfg_par = 2'b10;
    send(9'h03C, 8, 2, 1, 0, 0); idle(1);
    send(9'h0C3, 8, 2, 0, 0, 0); idle(2);
    check_head("R2", 9'h03C, 0, 1, 0);
    pop_one();
    check_head("R10", 9'h0C3, 0, 0, 0);
    pop_one();
    cfg_par = 2'b00;
  endtask

  task automatic t_frame;
    send(9'h05A, 8, 0, 0, 1, 0); idle(2);
    check_head("R3", 9'h05A, 1, 0, 0);
    pop_one();
    check("R4", "no entry after stop low", rx_ready, 0);
    send(9'h011, 8, 0, 0, 0, 0);
    send(9'h022, 8, 0, 0, 0, 0);
    idle(2);
    check_head("R3", 9'h011, 0, 0, 0); pop_one();
    check_head("R3", 9'h022, 0, 0, 0); pop_one();
  endtask

  task automatic t_false;
    @(negedge clk) rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    idle(3);
    check("R4", "short low ignored", rx_ready, 0);
    send(9'h09C, 8, 0, 0, 0, 0); idle(2);
    check_head("R4", 9'h09C, 0, 0, 0); pop_one();
  endtask

  task automatic t_glitch;
    send(9'h0E1, 8, 0, 0, 0, 1); idle(2);
    check_head("R5", 9'h0E1, 0, 0, 0); pop_one();
  endtask

  task automatic t_empty_pop;
    pop_one();
    check("R6", "pop on empty", rx_ready, 0);
    send(9'h033, 8, 0, 0, 0, 0); idle(2);
    check_head("R6", 9'h033, 0, 0, 0);
    pop_one();
    check("R6", "single entry", rx_ready, 0);
  endtask

  task automatic t_third;
    send(9'h0A1, 8, 0, 0, 0, 0); idle(1);
    send(9'h0A2, 8, 0, 0, 0, 0); idle(1);
    send(9'h0A3, 8, 0, 0, 0, 0); idle(2);
    check_head("R7", 9'h0A1, 0, 0, 0); pop_one();
    check_head("R7", 9'h0A2, 0, 0, 0); pop_one();
    check_head("R7", 9'h0A3, 0, 0, 0); pop_one();
    check("R7", "drained", rx_ready, 0);
  endtask

  task automatic t_overrun;
    send(9'h0B1, 8, 0, 0, 0, 0); idle(1);
    send(9'h0B2, 8, 0, 0, 0, 0); idle(1);
    send(9'h0B3, 8, 0, 0, 0, 0); idle(1);
    send(9'h0B4, 8, 0, 0, 0, 0); idle(2);
    check_head("R8", 9'h0B1, 0, 0, 0); pop_one();
    check_head("R8", 9'h0B2, 0, 0, 0); pop_one();
    check_head("R8", 9'h0B4, 0, 0, 1); pop_one();
    check("R8", "drained", rx_ready, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_widths();
    t_parity();
    t_frame();
    t_false();
    t_glitch();
    t_empty_pop();
    t_third();
    t_overrun();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R6 watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule